// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees an I2C bus that a slave holds hung with SDA low. When the host writes the recovery command, and the master byte engine is not running a command, the sequencer takes over the open-drain pin drivers. It clocks SCL one full period at a time, with SDA released, until the slave lets SDA go high or until a parameterised number of pulses has been sent. It then drives a STOP condition, drops its busy flag and raises a sticky completion status bit.

The block uses the same quarter-period timing strobe as the byte engine. Every phase of the sequence moves forward only on that strobe. It brings both lines through a synchroniser and presents them as line status, so software can tell whether SDA came free. A second sticky bit records that SDA was still low when the sequence ended. Both status bits are write-one-to-clear, and when a set and a clear arrive in the same cycle, the set wins.

Top module: `i2c_bus_recover`

## Requirements
- R1: After reset, busy_o, done_o, stuck_o, scl_oe_o and sda_oe_o are 0, and scl_status_o and sda_status_o are 1.
- R2: A rec_start_i pulse has no effect while engine_busy_i is 1: busy_o stays 0 and neither line is driven.
- R3: A rec_start_i pulse, accepted while idle and with engine_busy_i at 0, sets busy_o and scl_oe_o on the next clock edge.
- R4: During the pulse train SDA is released. Each SCL low phase and each SCL high phase ends on a clock edge where tick_i is 1.
- R5: The train stops early when synchronised SDA reads 1 at the tick that ends an SCL high phase. No further pulse follows.
- R6: At most NPULSE SCL pulses are sent, with a default of 9.
- R7: The STOP sequence runs over three tick intervals in this order: SCL and SDA both driven low; then SCL released with SDA still low; then SDA released while SCL is high.
- R8: On the tick that ends the STOP, busy_o falls and done_o rises on the same clock edge.
- R9: At completion, stuck_o is loaded with the inverse of synchronised SDA. It is 1 only when SDA is still low.
- R10: clear_i at 1 clears done_o and stuck_o on the next edge, unless a completion occurs on that same edge. In that case the completion wins.
- R11: A rec_start_i pulse while busy_o is 1 is ignored. The pulse count and the length of the sequence do not change.
- R12: scl_status_o and sda_status_o follow scl_i and sda_i delayed by SYNC_STAGES clock edges, with a default of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Quarter-period timing strobe shared with the byte engine |
| rec_start_i | input | 1 | Recovery command pulse |
| engine_busy_i | input | 1 | Byte engine is executing a command |
| clear_i | input | 1 | Write-one-to-clear for done_o and stuck_o |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |
| busy_o | output | 1 | Recovery sequence in progress |
| done_o | output | 1 | Recovery completed (sticky) |
| stuck_o | output | 1 | SDA still low at completion (sticky) |
| scl_status_o | output | 1 | Synchronised SCL level |
| sda_status_o | output | 1 | Synchronised SDA level |

## Verification
An accepted command shows on busy_o and scl_oe_o one edge after the pulse is sampled. Every later phase change shows one edge after a sampled tick. done_o and stuck_o update on the same edge that drops busy_o, and the line status lags the pins by exactly SYNC_STAGES edges. The bench steps a behavioural model on each rising edge from the same inputs the design sees. It compares every output on the following falling edge, so each result is checked in the cycle it becomes due. Directed checks add SCL pulse counts for a fully stuck slave, for one that releases on the third pulse and for one that is already free.

// File: rtl/i2c_rcv_pkg.sv
package i2c_rcv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOW    = 3'd1,
    ST_HIGH   = 3'd2,
    ST_STOP_A = 3'd3,
    ST_STOP_B = 3'd4,
    ST_STOP_C = 3'd5
  } rcv_state_e;
endpackage

// File: rtl/i2c_rcv_sync.sv
module i2c_rcv_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '1;  // idle bus is high
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/i2c_rcv_pulse_ctr.sv
module i2c_rcv_pulse_ctr #(
  parameter int NPULSE = 9,
  localparam int CW    = $clog2(NPULSE + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);
  localparam logic [CW-1:0] LAST = CW'(NPULSE - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end

  assign last_o = (cnt_o == LAST);
endmodule

// File: rtl/i2c_rcv_fsm.sv
module i2c_rcv_fsm
  import i2c_rcv_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,
  input  logic engine_busy_i,
  input  logic sda_s_i,
  input  logic last_i,
  output logic clr_o,
  output logic inc_o,
  output logic finish_o,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic busy_o
);
  rcv_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    clr_o    = 1'b0;
    inc_o    = 1'b0;
    finish_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i && !engine_busy_i) begin
        state_d = ST_LOW;
        clr_o   = 1'b1;
      end
      ST_LOW:  if (tick_i) state_d = ST_HIGH;
      ST_HIGH: if (tick_i) begin
        inc_o   = 1'b1;
        // early exit once the slave has let go
        state_d = (sda_s_i || last_i) ? ST_STOP_A : ST_LOW;
      end
      ST_STOP_A: if (tick_i) state_d = ST_STOP_B;
      ST_STOP_B: if (tick_i) state_d = ST_STOP_C;
      ST_STOP_C: if (tick_i) begin
        state_d  = ST_IDLE;
        finish_o = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign scl_oe_o = (state_q == ST_LOW) || (state_q == ST_STOP_A);
  assign sda_oe_o = (state_q == ST_STOP_A) || (state_q == ST_STOP_B);
  assign busy_o   = (state_q != ST_IDLE);
endmodule

// File: rtl/i2c_rcv_status.sv
module i2c_rcv_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic finish_i,
  input  logic sda_s_i,
  input  logic clear_i,
  output logic done_o,
  output logic stuck_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o  <= 1'b0;
      stuck_o <= 1'b0;
    end else if (finish_i) begin  // set beats clear
      done_o  <= 1'b1;
      stuck_o <= !sda_s_i;
    end else if (clear_i) begin
      done_o  <= 1'b0;
      stuck_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_bus_recover.sv
module i2c_bus_recover #(
  parameter int NPULSE      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rec_start_i,
  input  logic engine_busy_i,
  input  logic clear_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic busy_o,
  output logic done_o,
  output logic stuck_o,
  output logic scl_status_o,
  output logic sda_status_o
);
  localparam int CW = $clog2(NPULSE + 1);

  logic [1:0]    line_s;
  logic          clr, inc, last, finish;
  logic [CW-1:0] cnt;

  i2c_rcv_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i({scl_i, sda_i}), .q_o(line_s)
  );

  assign scl_status_o = line_s[1];
  assign sda_status_o = line_s[0];

  i2c_rcv_pulse_ctr #(.NPULSE(NPULSE)) u_ctr (
    .clk_i, .rst_ni, .clr_i(clr), .inc_i(inc), .cnt_o(cnt), .last_o(last)
  );

  i2c_rcv_fsm u_fsm (
    .clk_i, .rst_ni, .tick_i,
    .start_i(rec_start_i), .engine_busy_i,
    .sda_s_i(line_s[0]), .last_i(last),
    .clr_o(clr), .inc_o(inc), .finish_o(finish),
    .scl_oe_o, .sda_oe_o, .busy_o
  );

  i2c_rcv_status u_status (
    .clk_i, .rst_ni, .finish_i(finish), .sda_s_i(line_s[0]),
    .clear_i, .done_o, .stuck_o
  );
endmodule

// File: rtl/i2c_bus_recover_chk.sv
module i2c_bus_recover_chk #(
  parameter int NPULSE = 9
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tick_i,
  input logic rec_start_i,
  input logic engine_busy_i,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic busy_o,
  input logic done_o
);
  int unsigned rises_q;
  logic        scl_oe_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rises_q       <= 0;
      scl_oe_prev_q <= 1'b0;
    end else begin
      scl_oe_prev_q <= scl_oe_o;
      if (!busy_o) rises_q <= 0;
      else if (scl_oe_o && !scl_oe_prev_q) rises_q <= rises_q + 1;
    end
  end

  a_r2_engine_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_start_i && engine_busy_i && !busy_o |=> !busy_o && !scl_oe_o);

  a_r3_start_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_start_i && !engine_busy_i && !busy_o |=> busy_o && scl_oe_o);

  a_r4_phase_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) && !$stable(scl_oe_o) |-> $past(tick_i));

  a_r6_pulse_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rises_q <= NPULSE + 1);

  a_r7_stop_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> !scl_oe_o && busy_o);

  a_r8_done_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  a_r8_done_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(busy_o) && !busy_o);
endmodule

bind i2c_bus_recover i2c_bus_recover_chk #(.NPULSE(NPULSE)) u_chk (
  .clk_i, .rst_ni, .tick_i, .rec_start_i, .engine_busy_i,
  .scl_oe_o, .sda_oe_o, .busy_o, .done_o
);

// File: tb/i2c_bus_recover_tb.sv
module i2c_bus_recover_tb_top;
  localparam int NPULSE = 9;
  localparam int SYNC   = 2;
  localparam int TDIV   = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, start = 1'b0, eng = 1'b0, clr = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1;
  logic scl_oe, sda_oe, busy, done, stuck, scl_st, sda_st;

  always #2 clk = ~clk;

  i2c_bus_recover #(.NPULSE(NPULSE), .SYNC_STAGES(SYNC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rec_start_i(start),
    .engine_busy_i(eng), .clear_i(clr), .scl_i(scl_in), .sda_i(sda_in),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy), .done_o(done),
    .stuck_o(stuck), .scl_status_o(scl_st), .sda_status_o(sda_st)
  );

  int checks = 0, errors = 0, cyc = 0, falls = 0, tcnt = 0;
  logic prev_scl_oe = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: 0 idle,1 low,2 high,3 stopA,4 stopB,5 stopC
  int  m_st = 0, m_cnt = 0;
  bit  m_done = 0, m_stuck = 0;
  bit  m_sda_h [SYNC];
  bit  m_scl_h [SYNC];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_done = 0; m_stuck = 0;
      for (int i = 0; i < SYNC; i++) begin m_sda_h[i] = 1; m_scl_h[i] = 1; end
    end else begin
      bit sv, fin;
      sv  = m_sda_h[SYNC-1];
      fin = 0;
      case (m_st)
        0: if (start && !eng) begin m_st = 1; m_cnt = 0; end
        1: if (tick) m_st = 2;
        2: if (tick) begin
             m_cnt++;
             m_st = (sv || m_cnt >= NPULSE) ? 3 : 1;
           end
        3: if (tick) m_st = 4;
        4: if (tick) m_st = 5;
        5: if (tick) begin m_st = 0; fin = 1; end
        default: m_st = 0;
      endcase
      if (fin) begin m_done = 1; m_stuck = !sv; end
      else if (clr) begin m_done = 0; m_stuck = 0; end
      for (int i = SYNC-1; i > 0; i--) begin
        m_sda_h[i] = m_sda_h[i-1]; m_scl_h[i] = m_scl_h[i-1];
      end
      m_sda_h[0] = sda_in; m_scl_h[0] = scl_in;
    end
  end

  // compare every cycle, mirror SCL, drive tick
  always @(negedge clk) begin
    if (rst_n) begin
      chk(scl_oe == (m_st == 1 || m_st == 3), "R4 scl_oe", scl_oe, (m_st == 1 || m_st == 3));
      chk(sda_oe == (m_st == 3 || m_st == 4), "R7 sda_oe", sda_oe, (m_st == 3 || m_st == 4));
      chk(busy == (m_st != 0), "R3 busy", busy, (m_st != 0));
      chk(done == m_done, "R8 done", done, m_done);
      chk(stuck == m_stuck, "R9 stuck", stuck, m_stuck);
      chk(sda_st == m_sda_h[SYNC-1], "R12 sda_status", sda_st, m_sda_h[SYNC-1]);
      chk(scl_st == m_scl_h[SYNC-1], "R12 scl_status", scl_st, m_scl_h[SYNC-1]);
      if (prev_scl_oe && !scl_oe) falls++;
      prev_scl_oe = scl_oe;
    end
    scl_in = !scl_oe;
    tcnt = (tcnt == TDIV-1) ? 0 : tcnt + 1;
    tick = (tcnt == 0);
  end

  task automatic pulse_start(input bit e);
    @(negedge clk); start = 1; eng = e;
    @(negedge clk); start = 0; eng = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    chk(!busy, "R8 completes", busy, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !stuck && !scl_oe && !sda_oe, "R1 outputs", {busy, done, stuck, scl_oe, sda_oe}, 0);
    chk(scl_st && sda_st, "R1 status", {scl_st, sda_st}, 3);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R2 blocked by byte engine
    pulse_start(1);
    repeat (3) @(negedge clk);
    chk(!busy && !scl_oe, "R2 ignored", {busy, scl_oe}, 0);

    // R6 fully stuck slave
    sda_in = 0; falls = 0;
    repeat (4) @(negedge clk);
    pulse_start(0);
    chk(busy, "R3 accepted", busy, 1);
    @(negedge clk);
    wait_idle();
    chk(falls == NPULSE + 1, "R6 pulse count", falls, NPULSE + 1);
    chk(done && stuck, "R9 stuck at end", {done, stuck}, 3);

    // R10 clear
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    chk(!done && !stuck, "R10 cleared", {done, stuck}, 0);

    // R5 release during third pulse
    falls = 0;
    pulse_start(0);
    while (falls < 3) @(negedge clk);
    sda_in = 1;
    wait_idle();
    chk(falls == 4, "R5 early stop", falls, 4);
    chk(done && !stuck, "R9 freed", {done, stuck}, 2);

    // R11 start while busy, bus already free
    @(negedge clk); clr = 1; @(negedge clk); clr = 0;
    falls = 0;
    pulse_start(0);
    repeat (3) @(negedge clk);
    pulse_start(0);
    wait_idle();
    chk(falls == 2, "R11 restart ignored", falls, 2);

    // R10 completion wins over held clear
    falls = 0; clr = 1;
    pulse_start(0);
    wait_idle();
    chk(done, "R10 set wins", done, 1);
    @(negedge clk);
    chk(!done, "R10 clear after", done, 0);
    clr = 0;
    repeat (4) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule